// File: doc/BRIEF.md
# Debug Snapshot Capture Sequencer

This block is a bus master that takes a consistent snapshot of a processor core's sampled program counter and execution context from the core's external debug register block. A single-cycle trigger starts a fixed, power-aware sequence. The sequence first releases the software lock on the debug registers and saves the power control register. It then asks for the core to be powered up and waits for that with a bounded, paced poll. Once power is up, it pins the core powered with a no-power-down request and checks that access is allowed. Only then does it read the sample registers. Every path ends by writing the saved power control value back.

The results are held in registers. When the sequence ends, a one-cycle done pulse marks them as valid. They are the low and high program counter words, the context identifier, the virtual-machine state word and the last power status word. Three flags come with them: power-up failure, access refused, and sampling prohibited. A feature-level input, latched at the trigger, sets which companion registers the core implements.

The register bus is a request channel with a valid/ready handshake and a response channel with a valid strobe. Writes also wait for their response. Only one transaction is ever in flight.

Top module: `dbgcap_seq`

## Requirements
- R1: After reset, `req_valid`, `busy`, `done`, all three flags and all captured words are 0.
- R2: When a trigger arrives while idle, the first transaction writes 0 to the lock register (offset 0x300). The second reads the power control register (offset 0x310) and keeps that value as the saved copy.
- R3: A power-up request reads power control and writes the same value back with bit 3 set. The next transaction reads the power status register (offset 0x314).
- R4: A status poll that finds bit 0 clear is followed by a wait. At least `POLL_INTERVAL` cycles pass between that poll's response and the request of the next poll. Once `POLL_LIMIT/POLL_INTERVAL` waits have been used, the next failing poll ends polling: `pwr_fail` and `no_access` are set and the sequence jumps to the restore step.
- R5: After a poll sees bit 0 set, the sequencer reads power control and writes it back with bits 3 and 0 set. It then reads status again. If bit 0 is clear on that read, it restarts from the R3 power-up request with a fresh poll budget.
- R6: Sample reads happen only when that final status read has bit 0 = 1 and bit 6 = 0. Otherwise `no_access` is set and no sample register is read.
- R7: The program counter sample is read from offset 0x0A0 and lands on `pc_lo`. If it equals all ones, `prohibited` is set and no companion register is read.
- R8: Companion registers are read only after the sample, in this order: high PC word at 0x0AC (when `WIDE_PC` is 1), context ID at 0x0A4 (only when `feat_level` >= 2), VM state at 0x0A8 (only when `feat_level` == 3).
- R9: On every path, the last transaction writes the saved power control value to power control. `done` rises only after that write's response.
- R10: A request stays valid with stable write, address and data until it is accepted. No new request is raised while a response is pending.
- R11: `done` is a one-cycle pulse. Captured words are cleared at the trigger, so a word that was not read shows 0. `stat_word` holds the last status read. A prohibited result excludes both `pwr_fail` and `no_access`, and `pwr_fail` always comes with `no_access`.
- R12: A trigger that arrives while `busy` is high is ignored. The running sequence is not restarted or extended, and no extra sequence follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trigger | input | 1 | Start pulse |
| feat_level | input | 2 | Implemented sample feature level, latched at start |
| req_valid | output | 1 | Bus request valid |
| req_write | output | 1 | Request is a write |
| req_addr | output | ADDR_W | Register offset |
| req_wdata | output | DATA_W | Write data |
| req_ready | input | 1 | Request accepted |
| rsp_valid | input | 1 | Response strobe for the pending request |
| rsp_rdata | input | DATA_W | Read data |
| busy | output | 1 | Sequence running |
| done | output | 1 | One-cycle completion pulse |
| pwr_fail | output | 1 | Power-up poll gave up |
| no_access | output | 1 | Access refused (power off or double lock) |
| prohibited | output | 1 | Sample read as all ones |
| pc_lo | output | DATA_W | Sampled PC, low word |
| pc_hi | output | DATA_W | Sampled PC, high word |
| ctx_id | output | DATA_W | Context identifier sample |
| vm_state | output | DATA_W | Virtual-machine state sample |
| stat_word | output | DATA_W | Last power status value read |

## Verification
On every cycle, the assertions check the bus discipline: requests are held until accepted and only one is outstanding. They also check that done is preceded by a restore write carrying the value first read from power control, and that no sample or companion read occurs without a permitting status or a sufficient feature level. They also check that flag combinations are consistent and that only one unlock write occurs per sequence. The bench's scenarios are needed for the things that depend on the order of the whole transaction stream. These are the exact poll count at the timeout boundary, the spacing of polls, the retry after power is lost, the skipping of companions on an all-ones sample, and the captured values themselves.

// File: rtl/dbgcap_pkg.sv
package dbgcap_pkg;
  localparam int unsigned OFS_LOCK    = 12'h300;
  localparam int unsigned OFS_PWRCTL  = 12'h310;
  localparam int unsigned OFS_PWRSTAT = 12'h314;
  localparam int unsigned OFS_PCLO    = 12'h0A0;
  localparam int unsigned OFS_CTXID   = 12'h0A4;
  localparam int unsigned OFS_VMST    = 12'h0A8;
  localparam int unsigned OFS_PCHI    = 12'h0AC;

  localparam int unsigned BIT_POWERED = 0;
  localparam int unsigned BIT_DLOCK   = 6;
  localparam int unsigned BIT_PUREQ   = 3;
  localparam int unsigned BIT_NOPD    = 0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNLOCK, ST_SAVE, ST_PUREQ_RD, ST_PUREQ_WR, ST_POLL_RD,
    ST_POLL_WAIT, ST_NPD_RD, ST_NPD_WR, ST_STAT_RD, ST_PC_RD, ST_HI_RD,
    ST_CTX_RD, ST_VM_RD, ST_RESTORE
  } seq_state_t;
endpackage

// File: rtl/dbgcap_bus_port.sv
module dbgcap_bus_port #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              op_wr,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] op_wdata,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              xfer_done,
  output logic [DATA_W-1:0] xfer_rdata
);
  logic pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
      pend      <= 1'b0;
    end else begin
      if (start) begin
        req_valid <= 1'b1;
        req_write <= op_wr;
        req_addr  <= op_addr;
        req_wdata <= op_wdata;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
      if (req_valid && req_ready) pend <= 1'b1;
      else if (rsp_valid && pend) pend <= 1'b0;
    end
  end

  assign xfer_done  = rsp_valid && pend;
  assign xfer_rdata = rsp_rdata;
endmodule

// File: rtl/dbgcap_poll_timer.sv
module dbgcap_poll_timer #(
  parameter int POLL_INTERVAL = 1000,
  parameter int POLL_LIMIT    = 32000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic start,
  output logic tick,
  output logic exhausted
);
  localparam int MAX_WAITS = POLL_LIMIT / POLL_INTERVAL;
  localparam int CW = $clog2(POLL_INTERVAL + 1);
  localparam int WW = $clog2(MAX_WAITS + 1);

  logic [CW-1:0] cnt;
  logic [WW-1:0] waits;
  logic          run;

  assign tick      = run && (cnt == CW'(POLL_INTERVAL - 1));
  assign exhausted = (waits == WW'(MAX_WAITS));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      waits <= '0;
      run   <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (tick) begin
        run   <= 1'b0;
        waits <= waits + 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbgcap_seq.sv
module dbgcap_seq
  import dbgcap_pkg::*;
#(
  parameter int ADDR_W        = 12,
  parameter int DATA_W        = 32,
  parameter int POLL_INTERVAL = 1000,
  parameter int POLL_LIMIT    = 32000,
  parameter bit WIDE_PC       = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trigger,
  input  logic [1:0]        feat_level,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_wdata,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_rdata,
  output logic              busy,
  output logic              done,
  output logic              pwr_fail,
  output logic              no_access,
  output logic              prohibited,
  output logic [DATA_W-1:0] pc_lo,
  output logic [DATA_W-1:0] pc_hi,
  output logic [DATA_W-1:0] ctx_id,
  output logic [DATA_W-1:0] vm_state,
  output logic [DATA_W-1:0] stat_word
);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_PWRCTL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_PWRSTAT);
  localparam logic [ADDR_W-1:0] A_PCLO = ADDR_W'(OFS_PCLO);
  localparam logic [ADDR_W-1:0] A_PCHI = ADDR_W'(OFS_PCHI);
  localparam logic [ADDR_W-1:0] A_CTX  = ADDR_W'(OFS_CTXID);
  localparam logic [ADDR_W-1:0] A_VM   = ADDR_W'(OFS_VMST);
  localparam logic [DATA_W-1:0] M_PUREQ = DATA_W'(1) << BIT_PUREQ;
  localparam logic [DATA_W-1:0] M_NOPD  = DATA_W'(1) << BIT_NOPD;

  seq_state_t        state, after_pc, after_hi;
  logic              issued, start, op_bus, op_wr;
  logic [ADDR_W-1:0] op_addr;
  logic [DATA_W-1:0] op_wdata, saved, tmp, rdata;
  logic              xfer_done, tick, exhausted, t_clr, t_start;
  logic [1:0]        feat_q;

  always_comb after_hi = (feat_q >= 2'd2) ? ST_CTX_RD : ST_RESTORE;

  generate
    if (WIDE_PC) begin : g_wide
      assign after_pc = ST_HI_RD;
    end else begin : g_narrow
      assign after_pc = after_hi;
    end
  endgenerate

  always_comb begin
    op_bus   = 1'b1;
    op_wr    = 1'b0;
    op_addr  = A_CTL;
    op_wdata = '0;
    case (state)
      ST_UNLOCK:   begin op_wr = 1'b1; op_addr = A_LOCK; end
      ST_SAVE, ST_PUREQ_RD, ST_NPD_RD: op_addr = A_CTL;
      ST_PUREQ_WR: begin op_wr = 1'b1; op_wdata = tmp | M_PUREQ; end
      ST_NPD_WR:   begin op_wr = 1'b1; op_wdata = tmp | M_PUREQ | M_NOPD; end
      ST_POLL_RD, ST_STAT_RD: op_addr = A_STAT;
      ST_PC_RD:    op_addr = A_PCLO;
      ST_HI_RD:    op_addr = A_PCHI;
      ST_CTX_RD:   op_addr = A_CTX;
      ST_VM_RD:    op_addr = A_VM;
      ST_RESTORE:  begin op_wr = 1'b1; op_wdata = saved; end
      default:     op_bus = 1'b0;
    endcase
  end

  assign start   = op_bus && !issued;
  assign t_clr   = (state == ST_PUREQ_WR) && xfer_done;
  assign t_start = (state == ST_POLL_RD) && xfer_done && !rdata[BIT_POWERED] && !exhausted;

  dbgcap_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .start(start), .op_wr(op_wr), .op_addr(op_addr),
    .op_wdata(op_wdata), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .xfer_done(xfer_done),
    .xfer_rdata(rdata)
  );

  dbgcap_poll_timer #(.POLL_INTERVAL(POLL_INTERVAL), .POLL_LIMIT(POLL_LIMIT)) u_timer (
    .clk(clk), .rst(rst), .clr(t_clr), .start(t_start), .tick(tick),
    .exhausted(exhausted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE; issued <= 1'b0; busy <= 1'b0; done <= 1'b0;
      pwr_fail <= 1'b0; no_access <= 1'b0; prohibited <= 1'b0;
      pc_lo <= '0; pc_hi <= '0; ctx_id <= '0; vm_state <= '0; stat_word <= '0;
      saved <= '0; tmp <= '0; feat_q <= '0;
    end else begin
      done <= 1'b0;
      if (start) issued <= 1'b1;
      if (state == ST_IDLE) begin
        if (trigger) begin
          busy <= 1'b1; feat_q <= feat_level; state <= ST_UNLOCK;
          pwr_fail <= 1'b0; no_access <= 1'b0; prohibited <= 1'b0;
          pc_lo <= '0; pc_hi <= '0; ctx_id <= '0; vm_state <= '0; stat_word <= '0;
        end
      end else if (state == ST_POLL_WAIT) begin
        if (tick) state <= ST_POLL_RD;
      end else if (xfer_done) begin
        issued <= 1'b0;
        case (state)
          ST_UNLOCK:   state <= ST_SAVE;
          ST_SAVE:     begin saved <= rdata; state <= ST_PUREQ_RD; end
          ST_PUREQ_RD: begin tmp <= rdata; state <= ST_PUREQ_WR; end
          ST_PUREQ_WR: state <= ST_POLL_RD;
          ST_POLL_RD: begin
            stat_word <= rdata;
            if (rdata[BIT_POWERED]) state <= ST_NPD_RD;
            else if (exhausted) begin
              pwr_fail <= 1'b1; no_access <= 1'b1; state <= ST_RESTORE;
            end else state <= ST_POLL_WAIT;
          end
          ST_NPD_RD:   begin tmp <= rdata; state <= ST_NPD_WR; end
          ST_NPD_WR:   state <= ST_STAT_RD;
          ST_STAT_RD: begin
            stat_word <= rdata;
            if (!rdata[BIT_POWERED]) state <= ST_PUREQ_RD;
            else if (rdata[BIT_DLOCK]) begin
              no_access <= 1'b1; state <= ST_RESTORE;
            end else state <= ST_PC_RD;
          end
          ST_PC_RD: begin
            pc_lo <= rdata;
            if (rdata == '1) begin prohibited <= 1'b1; state <= ST_RESTORE; end
            else state <= after_pc;
          end
          ST_HI_RD:  begin pc_hi <= rdata; state <= after_hi; end
          ST_CTX_RD: begin
            ctx_id <= rdata;
            state  <= (feat_q == 2'd3) ? ST_VM_RD : ST_RESTORE;
          end
          ST_VM_RD:  begin vm_state <= rdata; state <= ST_RESTORE; end
          ST_RESTORE: begin done <= 1'b1; busy <= 1'b0; state <= ST_IDLE; end
          default:   state <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dbgcap_seq_chk.sv
module dbgcap_seq_chk
  import dbgcap_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        feat_level,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              busy,
  input logic              done,
  input logic              pwr_fail,
  input logic              no_access,
  input logic              prohibited
);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(OFS_LOCK);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(OFS_PWRCTL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_PWRSTAT);
  localparam logic [ADDR_W-1:0] A_PCLO = ADDR_W'(OFS_PCLO);
  localparam logic [ADDR_W-1:0] A_CTX  = ADDR_W'(OFS_CTXID);
  localparam logic [ADDR_W-1:0] A_VM   = ADDR_W'(OFS_VMST);

  logic              acc, pend, pend_wr, saved_ok;
  logic [ADDR_W-1:0] pend_addr, lw_addr;
  logic [DATA_W-1:0] saved_v, lw_data, last_stat;
  logic [3:0]        lock_cnt;

  assign acc = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0; pend_wr <= 1'b0; pend_addr <= '0; saved_ok <= 1'b0;
      saved_v <= '0; lw_addr <= '0; lw_data <= '0; last_stat <= '0; lock_cnt <= '0;
    end else begin
      if (rsp_valid && pend) begin
        pend <= 1'b0;
        if (!pend_wr && pend_addr == A_CTL && !saved_ok) begin
          saved_v <= rsp_rdata; saved_ok <= 1'b1;
        end
        if (!pend_wr && pend_addr == A_STAT) last_stat <= rsp_rdata;
      end
      if (acc) begin
        pend <= 1'b1; pend_wr <= req_write; pend_addr <= req_addr;
        if (req_write) begin lw_addr <= req_addr; lw_data <= req_wdata; end
        if (req_write && req_addr == A_LOCK) lock_cnt <= lock_cnt + 1'b1;
      end
      if (done) begin saved_ok <= 1'b0; lock_cnt <= '0; end
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk)
    rst |=> !req_valid && !busy && !done);
  p_one_outstanding_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !pend);
  p_hold_request_r10: assert property (@(posedge clk) disable iff (rst)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_write) && $stable(req_wdata));
  p_restore_last_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> saved_ok && !pend && lw_addr == A_CTL && lw_data == saved_v);
  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  p_flags_prohib_r7: assert property (@(posedge clk) disable iff (rst)
    done && prohibited |-> !no_access && !pwr_fail);
  p_fail_flags_r4: assert property (@(posedge clk) disable iff (rst)
    done && pwr_fail |-> no_access && !last_stat[BIT_POWERED]);
  p_access_gate_r6: assert property (@(posedge clk) disable iff (rst)
    acc && req_addr == A_PCLO |-> last_stat[BIT_POWERED] && !last_stat[BIT_DLOCK]);
  p_ctx_gate_r8: assert property (@(posedge clk) disable iff (rst)
    acc && req_addr == A_CTX |-> feat_level >= 2'd2);
  p_vm_gate_r8: assert property (@(posedge clk) disable iff (rst)
    acc && req_addr == A_VM |-> feat_level == 2'd3);
  p_single_unlock_r12: assert property (@(posedge clk) disable iff (rst)
    acc && req_write && req_addr == A_LOCK |-> lock_cnt == 4'd0);
endmodule

bind dbgcap_seq dbgcap_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .feat_level(feat_level), .req_valid(req_valid),
  .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
  .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .busy(busy), .done(done), .pwr_fail(pwr_fail), .no_access(no_access),
  .prohibited(prohibited)
);

// File: tb/dbgcap_seq_test.sv
module dbgcap_seq_test;
  localparam int INTV = 4;
  localparam int LIM  = 16;
  localparam int MAXW = LIM / INTV;
  localparam logic [11:0] A_LOCK = 12'h300, A_CTL = 12'h310, A_STAT = 12'h314;
  localparam logic [11:0] A_PCLO = 12'h0A0, A_PCHI = 12'h0AC, A_CTX = 12'h0A4, A_VM = 12'h0A8;

  logic clk = 1'b0, rst = 1'b1, trigger = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [1:0] feat_level = 2'd3;
  logic [31:0] rsp_rdata = '0;
  logic req_valid, req_write, busy, done, pwr_fail, no_access, prohibited;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, pc_lo, pc_hi, ctx_id, vm_state, stat_word;

  always #5 clk = ~clk;

  dbgcap_seq #(.ADDR_W(12), .DATA_W(32), .POLL_INTERVAL(INTV), .POLL_LIMIT(LIM), .WIDE_PC(1'b1)) uut (
    .clk(clk), .rst(rst), .trigger(trigger), .feat_level(feat_level),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .busy(busy), .done(done), .pwr_fail(pwr_fail),
    .no_access(no_access), .prohibited(prohibited), .pc_lo(pc_lo), .pc_hi(pc_hi),
    .ctx_id(ctx_id), .vm_state(vm_state), .stat_word(stat_word)
  );

  typedef struct { bit wr; logic [11:0] addr; logic [31:0] data; bit poll; string tag; } item_t;
  item_t exq[$];

  int vectors = 0, errors = 0, gcyc = 0;
  logic [31:0] sc_ctl0, sc_pc, sc_hi, sc_ctx, sc_vm;
  int sc_pu_after;
  bit sc_drop, sc_dlk, sc_stall, sc_mid;
  bit e_fail, e_noacc, e_prohib;
  logic [31:0] e_pc, e_hi, e_ctx, e_vm, e_stat;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input bit wr, input logic [11:0] a, input logic [31:0] d, input bit p, input string t);
    item_t it;
    it.wr = wr; it.addr = a; it.data = d; it.poll = p; it.tag = t;
    exq.push_back(it);
  endtask

  // Reference: expected transaction stream and results from the requirements
  task automatic build();
    logic [31:0] ctl, dl;
    bit first, fin;
    exq.delete();
    ctl = sc_ctl0; dl = sc_dlk ? 32'h40 : 32'h0;
    e_fail = 0; e_noacc = 0; e_prohib = 0;
    e_pc = 0; e_hi = 0; e_ctx = 0; e_vm = 0; e_stat = 0;
    push(1, A_LOCK, 0, 0, "R2 unlock");
    push(0, A_CTL, sc_ctl0, 0, "R2 save");
    first = 1; fin = 0;
    while (!fin) begin
      push(0, A_CTL, ctl, 0, "R3 pureq read");
      ctl = ctl | 32'h8;
      push(1, A_CTL, ctl, 0, "R3 pureq write");
      if (sc_pu_after < 0 || sc_pu_after > MAXW) begin
        for (int i = 0; i <= MAXW; i++) push(0, A_STAT, dl, 1, "R4 poll");
        e_fail = 1; e_noacc = 1; e_stat = dl;
        break;
      end
      for (int i = 0; i < sc_pu_after; i++) push(0, A_STAT, dl, 1, "R4 poll");
      push(0, A_STAT, dl | 32'h1, 1, "R4 poll");
      push(0, A_CTL, ctl, 0, "R5 npd read");
      ctl = ctl | 32'h9;
      push(1, A_CTL, ctl, 0, "R5 npd write");
      if (sc_drop && first) begin
        push(0, A_STAT, dl, 0, "R5 recheck");
        first = 0;
      end else begin
        push(0, A_STAT, dl | 32'h1, 0, "R5 recheck");
        e_stat = dl | 32'h1;
        fin = 1;
      end
    end
    if (!e_fail) begin
      if (sc_dlk) e_noacc = 1;
      else begin
        push(0, A_PCLO, sc_pc, 0, "R7 pc read");
        e_pc = sc_pc;
        if (sc_pc == 32'hFFFF_FFFF) e_prohib = 1;
        else begin
          push(0, A_PCHI, sc_hi, 0, "R8 hi read"); e_hi = sc_hi;
          if (feat_level >= 2) begin push(0, A_CTX, sc_ctx, 0, "R8 ctx read"); e_ctx = sc_ctx; end
          if (feat_level == 3) begin push(0, A_VM, sc_vm, 0, "R8 vm read"); e_vm = sc_vm; end
        end
      end
    end
    push(1, A_CTL, sc_ctl0, 0, "R9 restore");
  endtask

  task automatic run_scn(input string name);
    int cyc, last_rsp;
    bit rsp_pend, got_done, prev_poll, cur_poll;
    logic [31:0] rsp_q;
    item_t it;
    build();
    @(negedge clk); trigger = 1'b1;
    @(negedge clk); trigger = 1'b0;
    cyc = 0; rsp_pend = 0; got_done = 0; prev_poll = 0; cur_poll = 0; last_rsp = 0; rsp_q = 0;
    while (cyc < 3000 && !got_done) begin
      cyc++;
      rsp_valid = 1'b0;
      if (sc_mid) trigger = (cyc == 6 || cyc == 30);
      if (rsp_pend) begin
        rsp_valid = 1'b1; rsp_rdata = rsp_q; rsp_pend = 0;
        if (cur_poll) last_rsp = cyc;
      end
      if (done) begin
        got_done = 1;
        chk(exq.size() == 0, "R9 restore is last transaction", exq.size(), 0);
        chk(pwr_fail == e_fail, "R4 pwr_fail", pwr_fail, e_fail);
        chk(no_access == e_noacc, "R6 no_access", no_access, e_noacc);
        chk(prohibited == e_prohib, "R7 prohibited", prohibited, e_prohib);
        chk(pc_lo == e_pc, "R7 pc_lo", pc_lo, e_pc);
        chk(pc_hi == e_hi, "R8 pc_hi", pc_hi, e_hi);
        chk(ctx_id == e_ctx, "R8 ctx_id", ctx_id, e_ctx);
        chk(vm_state == e_vm, "R8 vm_state", vm_state, e_vm);
        chk(stat_word == e_stat, "R11 stat_word", stat_word, e_stat);
        chk(!busy, "R11 busy drops with done", busy, 0);
      end else begin
        if (!busy) chk(0, "R12 busy held during sequence", busy, 1);
        req_ready = sc_stall ? (cyc % 3 == 0) : 1'b1;
        if (req_valid && req_ready) begin
          if (exq.size() == 0) chk(0, "R9 no transaction after restore", req_addr, 0);
          else begin
            it = exq.pop_front();
            chk(req_write == it.wr && req_addr == it.addr, {it.tag, " kind/addr"},
                {19'd0, req_write, req_addr}, {19'd0, it.wr, it.addr});
            if (it.wr) chk(req_wdata == it.data, {it.tag, " wdata"}, req_wdata, it.data);
            if (it.poll && prev_poll)
              chk(cyc - last_rsp >= INTV, "R4 poll spacing", cyc - last_rsp, INTV);
            prev_poll = it.poll; cur_poll = it.poll;
            rsp_q = it.wr ? 32'h0 : it.data;
            rsp_pend = 1;
          end
        end
      end
      @(negedge clk);
    end
    trigger = 1'b0; rsp_valid = 1'b0;
    chk(got_done, {"R11 done reached: ", name}, got_done, 1);
    for (int k = 0; k < 12; k++) begin
      chk(!req_valid && !done && !busy, "R12 idle after done", {req_valid, done, busy}, 0);
      @(negedge clk);
    end
  endtask

  task automatic defaults();
    sc_ctl0 = 32'h0000_0A00; sc_pc = 32'h8000_1234; sc_hi = 32'hFFFF_0001;
    sc_ctx = 32'h0000_0042; sc_vm = 32'h9000_0007; sc_pu_after = 0;
    sc_drop = 0; sc_dlk = 0; sc_stall = 0; sc_mid = 0; feat_level = 2'd3;
  endtask

  always @(posedge clk) begin
    gcyc++;
    if (gcyc > 150000) begin
      errors++; vectors++;
      $display("FAIL watchdog actual=%0d expected=%0d", gcyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!req_valid && !busy && !done && !pwr_fail && !no_access && !prohibited && pc_lo == 0 && stat_word == 0,
        "R1 reset state", {req_valid, busy, done}, 0);
    defaults(); run_scn("basic full feature");
    defaults(); sc_pu_after = 2; feat_level = 2'd2; sc_ctl0 = 32'h1; run_scn("slow power-up level 2");
    defaults(); feat_level = 2'd1; sc_pc = 32'h0040_0003; run_scn("level 1");
    defaults(); sc_pu_after = -1; run_scn("power-up timeout");
    defaults(); sc_pu_after = MAXW; run_scn("power-up on last poll");
    defaults(); sc_dlk = 1; run_scn("double lock");
    defaults(); sc_drop = 1; sc_pu_after = 1; run_scn("power lost retry");
    defaults(); sc_pc = 32'hFFFF_FFFF; run_scn("prohibited sample");
    defaults(); sc_stall = 1; sc_pu_after = 1; run_scn("ready stalls");
    defaults(); sc_mid = 1; run_scn("trigger while busy");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule